// File: doc/BRIEF.md
# Load-Order Violation Detector

This block keeps a small ring of in-flight loads, kept in program order. A load may finish and hand its data on while an older load is still waiting on a miss. That early data stays correct unless the cache line it came from is taken away before every older load has finished. The block records the cache line of each completed load. It compares each incoming invalidation snoop against the completed loads that still have an older load pending. On a match it asks for a memory-order flush, which rolls execution back to the retirement state. If no such invalidation arrives, out-of-order completion goes unremarked.

The load pipeline allocates an entry at dispatch and receives the entry's position. It reports the line address when the load completes, and retires loads from the oldest end. The cache supplies invalidation snoops. A detected violation empties the tracker, because every load that has not retired is squashed by the rollback.

Top module: `load_order_guard`

## Requirements
- R1: After reset, `flush_valid` is 0, `full` is 0 and `alloc_id` is 0.
- R2: Allocation hands out positions 0, 1, 2, ... in order, wrapping modulo DEPTH. `full` rises once DEPTH loads are outstanding.
- R3: A snoop whose line matches a completed load, while an older load is still pending, raises `flush_valid` in the following cycle. `flush_id` then carries that load's position.
- R4: A snoop that matches a completed load with no pending older load causes no flush.
- R5: A snoop that matches no completed load, such as a different line or a line of a still-pending load, causes no flush.
- R6: Addresses are compared after dropping the low LINE_OFF_W bits. With the defaults, 0x1004 matches 0x1000.
- R7: When several loads violate on one snoop, `flush_id` names the oldest in program order.
- R8: `flush_valid` lasts exactly one cycle. During that cycle the tracker is empty: `full` is 0, and `alloc_id` is 0 once no allocation is offered.
- R9: A snoop in the same cycle as a load's completion does not flag that load. A matching snoop one cycle later does.
- R10: Retiring the oldest completed load frees its entry, so `full` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| alloc_valid | input | 1 | allocate an entry for a new load |
| alloc_id | output | IDX_W | position the next allocation receives |
| full | output | 1 | all DEPTH entries in use |
| cmpl_valid | input | 1 | a load has completed |
| cmpl_id | input | IDX_W | position of the completing load |
| cmpl_addr | input | ADDR_W | address read by the completing load |
| retire_valid | input | 1 | retire the oldest load |
| snoop_valid | input | 1 | invalidation snoop present |
| snoop_addr | input | ADDR_W | address of the invalidated line |
| flush_valid | output | 1 | one-cycle memory-order flush request |
| flush_id | output | IDX_W | position of the oldest offending load |

## Verification
The assertions assume three things about the inputs. No allocation is offered while `full` is high. A completion names an entry that is still pending. A retirement happens only when the oldest entry has completed. The stimulus completes only entries it has allocated and not yet completed, and retires only after completing the oldest. It never allocates beyond DEPTH. It does not complete a load during a flush pulse, since every entry has just been cleared.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_DONE = 2'd2
   } slot_state_e;
endpackage

// File: rtl/ldg_ring_ptr.sv
module ldg_ring_ptr #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic             pop,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head  <= head + IDX_W'(pop);
         tail  <= tail + IDX_W'(push);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
endmodule

// File: rtl/ldg_slot_array.sv
module ldg_slot_array
   import ldg_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int LINE_W = 26,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          alloc_en,
   input  logic [IDX_W-1:0]              tail,
   input  logic                          cmpl_en,
   input  logic [IDX_W-1:0]              cmpl_id,
   input  logic [LINE_W-1:0]             cmpl_line,
   input  logic                          pop_en,
   input  logic [IDX_W-1:0]              head,
   output logic [DEPTH-1:0]              wait_o,
   output logic [DEPTH-1:0]              done_o,
   output logic [DEPTH-1:0][LINE_W-1:0]  line_o
);
   slot_state_e st [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            st[i]     <= SLOT_FREE;
            line_o[i] <= '0;
         end else if (alloc_en && tail == IDX_W'(i)) begin
            st[i] <= SLOT_WAIT;
         end else if (cmpl_en && cmpl_id == IDX_W'(i) && st[i] == SLOT_WAIT) begin
            st[i]     <= SLOT_DONE;
            line_o[i] <= cmpl_line;
         end else if (pop_en && head == IDX_W'(i)) begin
            st[i] <= SLOT_FREE;
         end
      end
      assign wait_o[i] = (st[i] == SLOT_WAIT);
      assign done_o[i] = (st[i] == SLOT_DONE);
   end

   assert_cmpl_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_en |-> st[cmpl_id] == SLOT_WAIT);
   assert_retire_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> st[head] == SLOT_DONE);
   assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> st[tail] == SLOT_FREE);
endmodule

// File: rtl/ldg_age_scan.sv
module ldg_age_scan #(
   parameter int DEPTH  = 8,
   parameter int LINE_W = 26,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IDX_W-1:0]              head,
   input  logic [DEPTH-1:0]              wait_i,
   input  logic [DEPTH-1:0]              done_i,
   input  logic [DEPTH-1:0][LINE_W-1:0]  line_i,
   input  logic                          snoop_en,
   input  logic [LINE_W-1:0]             snoop_line,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_id
);
   logic [DEPTH-1:0] older_wait;
   logic [DEPTH-1:0] hit_age;
   logic [IDX_W-1:0] pick;

   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [IDX_W-1:0] slot;
      assign slot = head + IDX_W'(k);
      if (k == 0) begin : g_first
         assign older_wait[k] = 1'b0;
      end else begin : g_rest
         logic [IDX_W-1:0] prev_slot;
         assign prev_slot     = head + IDX_W'(k - 1);
         assign older_wait[k] = older_wait[k-1] | wait_i[prev_slot];
      end
      assign hit_age[k] = snoop_en & done_i[slot] & older_wait[k]
                          & (line_i[slot] == snoop_line);
   end

   always_comb begin
      pick = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (hit_age[k]) pick = IDX_W'(k);
      end
   end

   assign hit    = |hit_age;
   assign hit_id = head + pick;

   assert_hit_needs_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> snoop_en);
endmodule

// File: rtl/load_order_guard.sv
module load_order_guard #(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 32,
   parameter int LINE_OFF_W = 6,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = IDX_W + 1,
   localparam int LINE_W = ADDR_W - LINE_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   output logic [IDX_W-1:0]  alloc_id,
   output logic              full,
   input  logic              cmpl_valid,
   input  logic [IDX_W-1:0]  cmpl_id,
   input  logic [ADDR_W-1:0] cmpl_addr,
   input  logic              retire_valid,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              flush_valid,
   output logic [IDX_W-1:0]  flush_id
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LINE_OFF_W < 0 || LINE_OFF_W >= ADDR_W) begin : g_bad_line
      $error("LINE_OFF_W must lie below ADDR_W");
   end

   logic [IDX_W-1:0]             head, tail;
   logic [CNT_W-1:0]             count;
   logic                         alloc_en, pop_en, hit;
   logic [IDX_W-1:0]             hit_id;
   logic [DEPTH-1:0]             wait_v, done_v;
   logic [DEPTH-1:0][LINE_W-1:0] line_v;

   assign alloc_en = alloc_valid & ~full;
   assign pop_en   = retire_valid & (count != '0);
   assign alloc_id = tail;

   ldg_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clear(hit),
      .push(alloc_en), .pop(pop_en),
      .head(head), .tail(tail), .count(count), .full(full)
   );

   ldg_slot_array #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .clear(hit),
      .alloc_en(alloc_en), .tail(tail),
      .cmpl_en(cmpl_valid), .cmpl_id(cmpl_id),
      .cmpl_line(cmpl_addr[ADDR_W-1:LINE_OFF_W]),
      .pop_en(pop_en), .head(head),
      .wait_o(wait_v), .done_o(done_v), .line_o(line_v)
   );

   ldg_age_scan #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .head(head),
      .wait_i(wait_v), .done_i(done_v), .line_i(line_v),
      .snoop_en(snoop_valid), .snoop_line(snoop_addr[ADDR_W-1:LINE_OFF_W]),
      .hit(hit), .hit_id(hit_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_valid <= 1'b0;
         flush_id    <= '0;
      end else begin
         flush_valid <= hit;
         flush_id    <= hit ? hit_id : flush_id;
      end
   end

   assert_flush_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> !flush_valid);
   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> (count == '0) && !full);
   assert_flush_from_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> $past(snoop_valid));
endmodule

// File: tb/load_order_guard_bench.sv
module load_order_guard_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        alloc_valid, cmpl_valid, retire_valid, snoop_valid;
   logic [2:0]  cmpl_id;
   logic [31:0] cmpl_addr, snoop_addr;
   logic [2:0]  alloc_id, flush_id;
   logic        full, flush_valid;
   int          n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   load_order_guard u_load_order_guard (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_id(alloc_id), .full(full),
      .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .cmpl_addr(cmpl_addr),
      .retire_valid(retire_valid),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .flush_valid(flush_valid), .flush_id(flush_id)
   );

   typedef struct packed {
      logic        al;
      logic        cm;
      logic [2:0]  cid;
      logic [31:0] ca;
      logic        sn;
      logic [31:0] sa;
      logic        ef;
      logic [2:0]  eid;
   } row_t;

   localparam int NROW = 14;
   localparam row_t TABLE [NROW] = '{
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b0, 1'b1, 3'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 32'h2000, 1'b0, 3'd0},
      '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 32'h1004, 1'b1, 3'd1},
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b0, 1'b1, 3'd0, 32'h3000, 1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 32'h3000, 1'b0, 3'd0},
      '{1'b0, 1'b1, 3'd2, 32'h4000, 1'b0, 32'h0,    1'b0, 3'd0},
      '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 32'h5000, 1'b0, 3'd0},
      '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 32'h403C, 1'b1, 3'd2}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; cmpl_valid = 0; retire_valid = 0; snoop_valid = 0;
      cmpl_id = 0; cmpl_addr = 0; snoop_addr = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      step();
      step();
      rst_n = 1;
   endtask

   task automatic alloc();
      alloc_valid = 1; step();
   endtask

   task automatic complete(input logic [2:0] id, input logic [31:0] a);
      cmpl_valid = 1; cmpl_id = id; cmpl_addr = a; step();
   endtask

   task automatic snoop(input logic [31:0] a);
      snoop_valid = 1; snoop_addr = a; step();
   endtask

   initial begin
      #(4 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      check("R1 flush_valid", 32'(flush_valid), 0);
      check("R1 full", 32'(full), 0);
      check("R1 alloc_id", 32'(alloc_id), 0);

      // table walk: R3, R4, R5, R6
      for (int r = 0; r < NROW; r++) begin
         alloc_valid = TABLE[r].al;
         cmpl_valid  = TABLE[r].cm;
         cmpl_id     = TABLE[r].cid;
         cmpl_addr   = TABLE[r].ca;
         snoop_valid = TABLE[r].sn;
         snoop_addr  = TABLE[r].sa;
         step();
         check($sformatf("R3/R4/R5/R6 row %0d flush_valid", r), 32'(flush_valid), 32'(TABLE[r].ef));
         if (TABLE[r].ef)
            check($sformatf("R3 row %0d flush_id", r), 32'(flush_id), 32'(TABLE[r].eid));
      end

      // R8: pulse lasts one cycle, tracker emptied
      do_reset();
      alloc(); alloc();
      complete(3'd1, 32'h7000);
      snoop(32'h7000);
      check("R8 flush_valid high", 32'(flush_valid), 1);
      check("R8 full low in pulse", 32'(full), 0);
      check("R8 alloc_id reset in pulse", 32'(alloc_id), 0);
      step();
      check("R8 flush_valid one cycle", 32'(flush_valid), 0);

      // R2 and R10: ordering, wrap, full, retire
      do_reset();
      for (int i = 0; i < 8; i++) begin
         check($sformatf("R2 alloc_id %0d", i), 32'(alloc_id), 32'(i));
         alloc();
      end
      check("R2 full after 8", 32'(full), 1);
      complete(3'd0, 32'h100);
      check("R10 full before retire", 32'(full), 1);
      retire_valid = 1; step();
      check("R10 full after retire", 32'(full), 0);
      check("R2 alloc_id wraps", 32'(alloc_id), 0);

      // R7: oldest violator named
      do_reset();
      for (int i = 0; i < 4; i++) alloc();
      complete(3'd3, 32'h9000);
      complete(3'd2, 32'h9010);
      snoop(32'h9000);
      check("R7 flush_valid", 32'(flush_valid), 1);
      check("R7 flush_id oldest", 32'(flush_id), 2);

      // R9: snoop in completion cycle does not flag
      do_reset();
      alloc(); alloc();
      cmpl_valid = 1; cmpl_id = 3'd1; cmpl_addr = 32'hA000;
      snoop_valid = 1; snoop_addr = 32'hA000;
      step();
      check("R9 same-cycle no flush", 32'(flush_valid), 0);
      snoop(32'hA000);
      check("R9 later snoop flush", 32'(flush_valid), 1);
      check("R9 flush_id", 32'(flush_id), 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule